// File: doc/BRIEF.md
# Rotate-Mask and Shift Unit

This block is the bit-manipulation datapath of a 32-bit integer pipeline. It covers two families of work. The first rotates a source word left and then either clears everything outside a mask or merges the rotated bits into an existing destination word. The second shifts left, shifts right logically or shifts right algebraically, and it also counts leading zeros. The mask comes from two 5-bit indices. Indices count from the most significant bit, and the mask wraps around the word when the start index is past the end index.

An operation select, the source word, the old destination word, a 6-bit amount and the two mask indices enter the block on one clock. The result and a condition nibble for record-form instructions are registered and appear on the next clock. Decode, flag registers and the summary-overflow bit are not part of this block; the condition nibble drives its lowest bit to zero.

Top module: `rotmask_unit`

## Requirements
- R1: When mask start is less than or equal to mask end, the mask sets index positions start through end inclusive. Index i is vector bit 31-i, so index 0 is the MSB.
- R2: When mask start is greater than mask end, the mask sets indices 0 through end and indices start through 31.
- R3: Op 0 (rotate by immediate) and op 2 (rotate by register) rotate the source left by amt[4:0] and AND the rotated word with the mask. Bit amt[5] has no effect, and an amount of 0 passes the source through unchanged.
- R4: Op 1 (rotate-insert) rotates the source left by amt[4:0]. It takes the rotated bits where the mask is 1 and keeps the old destination bits where the mask is 0.
- R5: Op 3 (shift left) and op 4 (logical shift right) shift by amt[4:0] and fill with zeros. When amt[5] is 1 the result is 0.
- R6: Op 5 (algebraic shift right by register) shifts by amt[4:0] and fills the vacated high bits with source bit 31. When amt[5] is 1, every bit of the result equals source bit 31.
- R7: Op 6 (algebraic shift right by immediate) shifts by amt[4:0] with sign fill. Bit amt[5] is ignored.
- R8: Op 7 returns the number of leading zero bits of the source, from 0 to 32. A zero source gives 32.
- R9: cr0 is {negative, positive, zero, 0}. The result read as a signed number sets exactly one of bits 3, 2 and 1, and bit 0 is always 0.
- R10: The result and cr0 update on the clock edge after the inputs are applied. A synchronous active-low reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 3 | Operation select (codes as in R3 to R8) |
| src | input | 32 | Source word |
| dst_old | input | 32 | Previous destination word, used by rotate-insert |
| amt | input | 6 | Rotate or shift amount; bit 5 is the saturate bit for register shifts |
| mask_start | input | 5 | First mask index, MSB-first |
| mask_end | input | 5 | Last mask index, MSB-first |
| result | output | 32 | Registered result |
| cr0 | output | 4 | Registered condition nibble {neg, pos, zero, 0} |

## Verification
Every result and every cr0 nibble is due exactly one clock edge after its inputs are applied. The bench drives inputs on the falling edge and keeps them for one full cycle. It samples both outputs on the following falling edge and compares them with a reference model that it computed when it drove those inputs. Reset is checked in the same way: the outputs are sampled one falling edge after a clock edge taken with reset held low, including a reset that arrives while the outputs hold nonzero values.

// File: rtl/rmu_pkg.sv
// Package: shared widths and operation codes for the rotate-mask unit.
// Assumes a power-of-two word width.
package rmu_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int AMT_W  = IDX_W + 1;

    typedef enum logic [2:0] {
        OP_ROT_AND_IMM = 3'd0,
        OP_ROT_INSERT  = 3'd1,
        OP_ROT_AND_REG = 3'd2,
        OP_SHL         = 3'd3,
        OP_SHR_LOG     = 3'd4,
        OP_SHR_ALG     = 3'd5,
        OP_SHR_ALG_IMM = 3'd6,
        OP_LZ_COUNT    = 3'd7
    } rmu_op_e;
endpackage

// File: rtl/rmu_mask.sv
// Module: builds a W-bit mask from start/end indices numbered from the MSB.
// Assumes both indices are in range 0..W-1; wraps when start > end.
module rmu_mask #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [IW-1:0] idx_start,
    input  logic [IW-1:0] idx_end,
    output logic [W-1:0]  mask
);
    logic wrap;

    // Purpose: detect the wrapping form of the mask.
    always_comb wrap = idx_start > idx_end;

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [IW-1:0] POS = IW'(i);
        logic ge_start, le_end;
        // Purpose: decide whether MSB-first index i lies inside the mask.
        always_comb begin
            ge_start = POS >= idx_start;
            le_end   = POS <= idx_end;
            mask[W-1-i] = wrap ? (ge_start | le_end) : (ge_start & le_end);
        end
    end
endmodule

// File: rtl/rmu_rotate.sv
// Module: rotates a W-bit word left by a log2(W)-bit amount.
// Assumes the amount is already reduced to its low bits.
module rmu_rotate #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [IW-1:0] sh,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] doubled;

    // Purpose: shift a doubled copy so the upper half holds the rotation.
    always_comb begin
        doubled = {din, din} << sh;
        dout    = doubled[2*W-1:W];
    end
endmodule

// File: rtl/rmu_shift.sv
// Module: left, logical-right and algebraic-right shifts.
// Assumes amt carries log2(W) shift bits plus one saturate bit on top.
module rmu_shift #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [IW:0]   amt,
    output logic [W-1:0]  shl_out,
    output logic [W-1:0]  shr_out,
    output logic [W-1:0]  sra_out,
    output logic [W-1:0]  sra_imm_out
);
    logic          sat;
    logic [IW-1:0] sh;
    logic [W-1:0]  arith;

    // Purpose: form the four shift variants; only register forms saturate.
    always_comb begin
        sat         = amt[IW];
        sh          = amt[IW-1:0];
        arith       = W'($signed(din) >>> sh);
        shl_out     = sat ? '0 : din << sh;
        shr_out     = sat ? '0 : din >> sh;
        sra_out     = sat ? {W{din[W-1]}} : arith;
        sra_imm_out = arith;
    end
endmodule

// File: rtl/rmu_lzc.sv
// Module: counts leading zero bits of a W-bit word; all-zero gives W.
// Assumes nothing about the input.
module rmu_lzc #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0] din,
    output logic [IW:0]  count
);
    // Purpose: scan from the LSB so the last hit is the highest set bit.
    always_comb begin
        count = (IW+1)'(W);
        for (int i = 0; i < W; i++) begin
            if (din[i]) count = (IW+1)'(W - 1 - i);
        end
    end
endmodule

// File: rtl/rotmask_unit.sv
// Module: top of the rotate-mask and shift unit. Selects one operation,
// registers the result and the record-form condition nibble.
// Assumes op, src, dst_old, amt and mask indices are stable around the edge.
module rotmask_unit
    import rmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] dst_old,
    input  logic [AMT_W-1:0]  amt,
    input  logic [IDX_W-1:0]  mask_start,
    input  logic [IDX_W-1:0]  mask_end,
    output logic [WORD_W-1:0] result,
    output logic [3:0]        cr0
);
    logic [WORD_W-1:0] mask, rotated;
    logic [WORD_W-1:0] shl_v, shr_v, sra_v, srai_v;
    logic [AMT_W-1:0]  lz;
    logic [WORD_W-1:0] nxt_result;
    logic [3:0]        nxt_cr0;
    rmu_op_e           op_e;

    rmu_mask #(.W(WORD_W)) u_mask (
        .idx_start (mask_start),
        .idx_end   (mask_end),
        .mask      (mask)
    );

    rmu_rotate #(.W(WORD_W)) u_rot (
        .din  (src),
        .sh   (amt[IDX_W-1:0]),
        .dout (rotated)
    );

    rmu_shift #(.W(WORD_W)) u_shift (
        .din         (src),
        .amt         (amt),
        .shl_out     (shl_v),
        .shr_out     (shr_v),
        .sra_out     (sra_v),
        .sra_imm_out (srai_v)
    );

    rmu_lzc #(.W(WORD_W)) u_lzc (
        .din   (src),
        .count (lz)
    );

    // Purpose: choose the result of the selected operation.
    always_comb begin
        op_e = rmu_op_e'(op);
        unique case (op_e)
            OP_ROT_AND_IMM,
            OP_ROT_AND_REG: nxt_result = rotated & mask;
            OP_ROT_INSERT:  nxt_result = (dst_old & ~mask) | (rotated & mask);
            OP_SHL:         nxt_result = shl_v;
            OP_SHR_LOG:     nxt_result = shr_v;
            OP_SHR_ALG:     nxt_result = sra_v;
            OP_SHR_ALG_IMM: nxt_result = srai_v;
            OP_LZ_COUNT:    nxt_result = WORD_W'(lz);
            default:        nxt_result = '0;
        endcase
    end

    // Purpose: signed compare of the next result against zero.
    always_comb begin
        nxt_cr0[3] = nxt_result[WORD_W-1];
        nxt_cr0[1] = nxt_result == '0;
        nxt_cr0[2] = !nxt_cr0[3] && !nxt_cr0[1];
        nxt_cr0[0] = 1'b0;
    end

    // Purpose: output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            cr0    <= '0;
        end else begin
            result <= nxt_result;
            cr0    <= nxt_cr0;
        end
    end

    // ---------------- assertions ----------------
    assert_mask_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_start <= mask_end) |->
        ($countones(mask) == int'(mask_end) - int'(mask_start) + 1));

    assert_mask_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_start > mask_end) |->
        ($countones(mask) == WORD_W - int'(mask_start) + int'(mask_end) + 1));

    assert_insert_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1) |=> (((result ^ $past(dst_old)) & ~$past(mask)) == '0));

    assert_shift_sat_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 3'd3 || op == 3'd4) && amt[IDX_W]) |=> (result == '0));

    assert_sra_sat_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd5 && amt[IDX_W]) |=> (result == {WORD_W{$past(src[WORD_W-1])}}));

    assert_lz_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd7) |=> (result <= WORD_W));

    assert_cr_one_hot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(cr0[3:1]) == 1 && cr0[0] == 1'b0));

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && cr0 == '0));
endmodule

// File: tb/tb_rotmask_unit.sv
module tb_rotmask_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op;
    logic [31:0] src, dst_old, result;
    logic [5:0]  amt;
    logic [4:0]  mask_start, mask_end;
    logic [3:0]  cr0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rotmask_unit dut (
        .clk(clk), .rst_n(rst_n), .op(op), .src(src), .dst_old(dst_old),
        .amt(amt), .mask_start(mask_start), .mask_end(mask_end),
        .result(result), .cr0(cr0)
    );

    function automatic logic [31:0] m_mask(int s, int e);
        logic [31:0] m = '0;
        for (int i = 0; i < 32; i++) begin
            bit inside_m = (s <= e) ? (i >= s && i <= e) : (i >= s || i <= e);
            if (inside_m) m[31 - i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [31:0] m_rotl(logic [31:0] v, int n);
        for (int k = 0; k < n; k++) v = {v[30:0], v[31]};
        return v;
    endfunction

    function automatic logic [31:0] m_sra(logic [31:0] v, int n);
        for (int k = 0; k < n; k++) v = {v[31], v[31:1]};
        return v;
    endfunction

    function automatic logic [31:0] m_model(logic [2:0] o, logic [31:0] s, logic [31:0] d,
                                            logic [5:0] a, int ms, int me);
        int n = a[4:0];
        logic [31:0] m = m_mask(ms, me);
        logic [31:0] r = m_rotl(s, n);
        case (o)
            3'd0, 3'd2: return r & m;
            3'd1: return (d & ~m) | (r & m);
            3'd3: return a[5] ? 32'd0 : s << n;
            3'd4: return a[5] ? 32'd0 : s >> n;
            3'd5: return a[5] ? {32{s[31]}} : m_sra(s, n);
            3'd6: return m_sra(s, n);
            default: begin
                int c = 0;
                while (c < 32 && s[31 - c] == 1'b0) c++;
                return 32'(c);
            end
        endcase
    endfunction

    function automatic logic [3:0] m_cr(logic [31:0] r);
        if ($signed(r) < 0) return 4'b1000;
        if ($signed(r) > 0) return 4'b0100;
        return 4'b0010;
    endfunction

    function automatic string tag_of(logic [2:0] o, int ms, int me);
        string mt = (ms <= me) ? "R1" : "R2";
        case (o)
            3'd0, 3'd2: return {"R3/", mt};
            3'd1: return {"R4/", mt};
            3'd3, 3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, sample on the next falling edge.
    task automatic step(logic [2:0] o, logic [31:0] s, logic [31:0] d,
                        logic [5:0] a, logic [4:0] ms, logic [4:0] me);
        logic [31:0] er;
        op = o; src = s; dst_old = d; amt = a; mask_start = ms; mask_end = me;
        er = m_model(o, s, d, a, int'(ms), int'(me));
        @(negedge clk);
        check(tag_of(o, int'(ms), int'(me)), result, er);
        check("R9", 32'(cr0), 32'(m_cr(er)));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op = '0; src = 32'hDEAD_BEEF; dst_old = '0;
        amt = '0; mask_start = '0; mask_end = 5'd31;
        @(negedge clk); @(negedge clk);
        check("R10 reset result", result, 32'd0);
        check("R10 reset cr0", 32'(cr0), 32'd0);
        rst_n = 1'b1;

        // masks: plain, single bit, full, wrap (R1, R2, R3)
        step(3'd0, 32'hFFFF_FFFF, 0, 6'd0, 5'd4, 5'd11);
        step(3'd0, 32'h1234_5678, 0, 6'd0, 5'd0, 5'd31);
        step(3'd0, 32'hFFFF_FFFF, 0, 6'd0, 5'd7, 5'd7);
        step(3'd0, 32'hFFFF_FFFF, 0, 6'd0, 5'd28, 5'd3);
        step(3'd0, 32'h8000_0001, 0, 6'd4, 5'd0, 5'd31);
        step(3'd2, 32'h8000_0001, 0, 6'd36, 5'd0, 5'd31);
        step(3'd2, 32'hF000_000F, 0, 6'd63, 5'd30, 5'd1);
        // insert (R4)
        step(3'd1, 32'h0000_00AB, 32'h1111_1111, 6'd8, 5'd16, 5'd23);
        step(3'd1, 32'hFFFF_FFFF, 32'h0000_0000, 6'd0, 5'd31, 5'd0);
        // shifts (R5, R6, R7)
        step(3'd3, 32'h0000_0001, 0, 6'd31, 0, 0);
        step(3'd3, 32'hFFFF_FFFF, 0, 6'd32, 0, 0);
        step(3'd4, 32'h8000_0000, 0, 6'd31, 0, 0);
        step(3'd4, 32'hFFFF_FFFF, 0, 6'd40, 0, 0);
        step(3'd5, 32'h8000_0000, 0, 6'd4, 0, 0);
        step(3'd5, 32'h8765_4321, 0, 6'd40, 0, 0);
        step(3'd5, 32'h7765_4321, 0, 6'd33, 0, 0);
        step(3'd6, 32'h8000_0000, 0, 6'd37, 0, 0);
        step(3'd6, 32'h4000_0000, 0, 6'd0, 0, 0);
        // leading zeros (R8)
        step(3'd7, 32'h0000_0000, 0, 0, 0, 0);
        step(3'd7, 32'h0000_0001, 0, 0, 0, 0);
        step(3'd7, 32'h8000_0000, 0, 0, 0, 0);
        step(3'd7, 32'h0001_0000, 0, 0, 0, 0);

        // reset while outputs are nonzero (R10)
        step(3'd0, 32'hFFFF_FFFF, 0, 6'd0, 5'd0, 5'd31);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid-run reset result", result, 32'd0);
        check("R10 mid-run reset cr0", 32'(cr0), 32'd0);
        rst_n = 1'b1;

        for (int k = 0; k < 800; k++) begin
            step(3'($urandom), $urandom, $urandom, 6'($urandom),
                 5'($urandom), 5'($urandom));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule